// File: doc/BRIEF.md
# Programmable LCD Sync Timing Generator

This block produces the raster timing for a TFT panel driven in parallel or over an 8-bit serial RGB link. It runs on the pixel clock and keeps a horizontal counter in clocks and a vertical counter in lines. From these counters it derives the horizontal sync, vertical sync and data-enable outputs. During the visible area it also gives the zero-based column and row of the current pixel. A one-clock line-start strobe and a one-clock frame-start strobe mark the raster origin for downstream pixel logic.

All timing comes from registers that software writes through a simple write port: a word address and a 32-bit data word. Every window register holds two absolute positions, a start and an end. Software writes into shadow copies. The generator copies the whole set into its working set only at a frame boundary, or when it starts from idle, so no frame ever runs with a mix of old and new settings. A control register starts the generator and asks it to stop. A stop request completes the current frame, and the outputs then rest at their inactive levels.

Top module: `lcd_sync_gen`

## Requirements
- R1: Each window register packs the start position in bits 31:16 and the end position in bits 15:0. The word addresses are: 0 configuration, 1 horizontal sync, 2 vertical sync, 3 totals (clocks per line in bits 31:16, lines per frame in bits 15:0), 4 horizontal display window, 5 vertical display window, 6 control.
- R2: While running, the horizontal counter steps 0 to total-1 and then wraps, and the vertical counter advances on each wrap. line_start is high when the horizontal count is 0. frame_start is high when both counts are 0.
- R3: The hsync output is active when the horizontal count lies in [start, end) of the horizontal sync register. The vsync output is active when the line count lies in [start, end) of the vertical sync register.
- R4: de is active only when both counts lie inside their display windows (start inclusive, end exclusive). pix_x and pix_y then give the offsets from the window starts, and both are 0 whenever de is inactive.
- R5: Configuration bit 8 inverts vsync, bit 9 inverts de and bit 11 inverts hsync. Bit 10 is presented on pclk_falling.
- R6: Configuration bits 3:0 select the mode: 0x0 is generic TFT and 0xC is 8-bit serial RGB. In serial mode each pixel takes three clocks. The horizontal window end and the line total are each extended by twice the window width, and pix_x advances every third clock. Any other mode value behaves as generic.
- R7: A control write with bit 3 set and bit 4 clear starts an idle generator at the raster origin on the next clock. While running, it cancels a pending stop. A control write with bit 4 set requests a stop, and bit 4 wins over bit 3. A stop takes effect after the last clock of the current frame.
- R8: While idle, hsync, vsync and de rest at their inactive levels (the value of their invert bits), and the strobes and coordinates are 0.
- R9: Register writes reach the working timing set only at the next frame start, or when the generator starts from idle.
- R10: After reset the generator is idle, every register is zero and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register word address |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, polarity as configured |
| vsync | output | 1 | Vertical sync, polarity as configured |
| de | output | 1 | Data enable, polarity as configured |
| pclk_falling | output | 1 | Pixel clock edge select for the panel |
| pix_x | output | 16 | Column inside the display window |
| pix_y | output | 16 | Row inside the display window |
| line_start | output | 1 | High at horizontal count 0 |
| frame_start | output | 1 | High at the raster origin |

## Verification
The hardest situations to reach are a register write and a stop request that arrive in the middle of a running frame. In both, the correct behaviour depends on the difference between the shadow settings and the working settings. The bench writes the polarity and the stop request at chosen cycle offsets well inside a frame. A cycle-level model in the bench keeps the pending and active settings apart, and it compares every output on every clock across the frame boundary where the change must first appear. The serial mode is swept over whole frames with the stretched window computed arithmetically in the bench.

// File: rtl/lcd_sync_pkg.sv
`timescale 1ns/1ps
package lcd_sync_pkg;

    localparam int POS_W = 16;

    localparam int A_CFG   = 0;
    localparam int A_HSYNC = 1;
    localparam int A_VSYNC = 2;
    localparam int A_TOTAL = 3;
    localparam int A_HWIN  = 4;
    localparam int A_VWIN  = 5;
    localparam int A_CTRL  = 6;

    localparam int CFG_INV_V    = 8;
    localparam int CFG_INV_DE   = 9;
    localparam int CFG_INV_PCLK = 10;
    localparam int CFG_INV_H    = 11;

    localparam int CTRL_RUN  = 3;
    localparam int CTRL_STOP = 4;

    localparam logic [3:0] MODE_SERIAL = 4'hC;

    typedef logic [POS_W-1:0] pos_t;

    typedef struct packed {
        pos_t s;
        pos_t e;
    } span_t;

    typedef struct packed {
        logic [3:0] mode;
        logic       inv_v;
        logic       inv_de;
        logic       inv_pclk;
        logic       inv_h;
        span_t      hs;
        span_t      vs;
        span_t      hwin;
        span_t      vwin;
        pos_t       htot;
        pos_t       vtot;
    } tset_t;

endpackage

// File: rtl/lcd_sync_regs.sv
`timescale 1ns/1ps
module lcd_sync_regs
    import lcd_sync_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output tset_t             shadow,
    output logic              cmd_run,
    output logic              cmd_stop
);

    tset_t shd_d, shd_q;
    logic  hit_ctrl;

    always_comb begin
        shd_d    = shd_q;
        hit_ctrl = 1'b0;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(A_CFG)) begin
                shd_d.mode     = wr_data[3:0];
                shd_d.inv_v    = wr_data[CFG_INV_V];
                shd_d.inv_de   = wr_data[CFG_INV_DE];
                shd_d.inv_pclk = wr_data[CFG_INV_PCLK];
                shd_d.inv_h    = wr_data[CFG_INV_H];
            end else if (wr_addr == ADDR_W'(A_HSYNC)) begin
                shd_d.hs = span_t'(wr_data);
            end else if (wr_addr == ADDR_W'(A_VSYNC)) begin
                shd_d.vs = span_t'(wr_data);
            end else if (wr_addr == ADDR_W'(A_TOTAL)) begin
                shd_d.htot = wr_data[31:16];
                shd_d.vtot = wr_data[15:0];
            end else if (wr_addr == ADDR_W'(A_HWIN)) begin
                shd_d.hwin = span_t'(wr_data);
            end else if (wr_addr == ADDR_W'(A_VWIN)) begin
                shd_d.vwin = span_t'(wr_data);
            end else if (wr_addr == ADDR_W'(A_CTRL)) begin
                hit_ctrl = 1'b1;
            end
        end
        cmd_stop = hit_ctrl && wr_data[CTRL_STOP];
        cmd_run  = hit_ctrl && wr_data[CTRL_RUN] && !wr_data[CTRL_STOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_q <= '0;
        end else begin
            shd_q <= shd_d;
        end
    end

    assign shadow = shd_q;

    // R10
    cfg_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (shd_q == '0));

endmodule

// File: rtl/lcd_sync_timing.sv
`timescale 1ns/1ps
module lcd_sync_timing
    import lcd_sync_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  tset_t shadow,
    input  logic  cmd_run,
    input  logic  cmd_stop,
    output logic  running,
    output pos_t  hcnt,
    output pos_t  vcnt,
    output pos_t  xcnt,
    output tset_t active
);

    typedef struct packed {
        logic       run;
        logic       stop;
        pos_t       h;
        pos_t       v;
        pos_t       x;
        logic [1:0] ph;
        tset_t      act;
    } st_t;

    st_t d, q;

    logic [POS_W:0] h_next, v_next;
    logic           h_last, v_last, f_last, in_hwin, serial;

    function automatic tset_t stretch(input tset_t s);
        tset_t r;
        pos_t  w;
        pos_t  w2;
        r  = s;
        w  = s.hwin.e - s.hwin.s;
        w2 = {w[POS_W-2:0], 1'b0};
        if (s.mode == MODE_SERIAL) begin
            r.hwin.e = s.hwin.e + w2;
            r.htot   = s.htot + w2;
        end
        return r;
    endfunction

    always_comb begin
        h_next  = {1'b0, q.h} + (POS_W+1)'(1);
        v_next  = {1'b0, q.v} + (POS_W+1)'(1);
        h_last  = h_next >= {1'b0, q.act.htot};
        v_last  = v_next >= {1'b0, q.act.vtot};
        f_last  = h_last && v_last;
        in_hwin = (q.h >= q.act.hwin.s) && (q.h < q.act.hwin.e);
        serial  = q.act.mode == MODE_SERIAL;

        d = q;
        if (!q.run) begin
            if (cmd_run) begin
                d.run  = 1'b1;
                d.stop = 1'b0;
                d.h    = '0;
                d.v    = '0;
                d.x    = '0;
                d.ph   = '0;
                d.act  = stretch(shadow);
            end
        end else begin
            if (f_last) begin
                d.h  = '0;
                d.v  = '0;
                d.x  = '0;
                d.ph = '0;
                if (q.stop) begin
                    d.run  = 1'b0;
                    d.stop = 1'b0;
                end else begin
                    d.act = stretch(shadow);
                end
            end else if (h_last) begin
                d.h  = '0;
                d.v  = q.v + POS_W'(1);
                d.x  = '0;
                d.ph = '0;
            end else begin
                d.h = q.h + POS_W'(1);
                if (in_hwin) begin
                    if (serial) begin
                        if (q.ph == 2'd2) begin
                            d.ph = '0;
                            d.x  = q.x + POS_W'(1);
                        end else begin
                            d.ph = q.ph + 2'd1;
                        end
                    end else begin
                        d.x = q.x + POS_W'(1);
                    end
                end
            end
            if (cmd_stop) begin
                d.stop = 1'b1;
            end else if (cmd_run) begin
                d.stop = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign running = q.run;
    assign hcnt    = q.h;
    assign vcnt    = q.v;
    assign xcnt    = q.x;
    assign active  = q.act;

    // R2
    h_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && q.act.htot != '0) |-> (q.h < q.act.htot));

    // R7
    stop_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.run) |-> $past(f_last));

    // R7
    start_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.run) |-> (q.h == '0 && q.v == '0));

    // R9
    act_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && !$stable(q.act)) |-> (q.h == '0 && q.v == '0));

endmodule

// File: rtl/lcd_sync_out.sv
`timescale 1ns/1ps
module lcd_sync_out
    import lcd_sync_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  running,
    input  pos_t  hcnt,
    input  pos_t  vcnt,
    input  pos_t  xcnt,
    input  tset_t active,
    output logic  hsync,
    output logic  vsync,
    output logic  de,
    output logic  pclk_falling,
    output pos_t  pix_x,
    output pos_t  pix_y,
    output logic  line_start,
    output logic  frame_start
);

    logic hs_act, vs_act, de_act, in_h, in_v;
    logic unused_fields;

    assign unused_fields = ^{active.htot, active.vtot, active.mode};

    always_comb begin
        in_h   = (hcnt >= active.hwin.s) && (hcnt < active.hwin.e);
        in_v   = (vcnt >= active.vwin.s) && (vcnt < active.vwin.e);
        hs_act = running && (hcnt >= active.hs.s) && (hcnt < active.hs.e);
        vs_act = running && (vcnt >= active.vs.s) && (vcnt < active.vs.e);
        de_act = running && in_h && in_v;

        hsync        = hs_act ^ active.inv_h;
        vsync        = vs_act ^ active.inv_v;
        de           = de_act ^ active.inv_de;
        pclk_falling = active.inv_pclk;
        pix_x        = de_act ? xcnt : '0;
        pix_y        = de_act ? (vcnt - active.vwin.s) : '0;
        line_start   = running && (hcnt == '0);
        frame_start  = running && (hcnt == '0) && (vcnt == '0);
    end

    // R8
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (hsync == active.inv_h && vsync == active.inv_v &&
                      de == active.inv_de && !line_start && !frame_start));

    // R2
    strobe_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> line_start);

    // R4
    row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de_act |-> (pix_y < (active.vwin.e - active.vwin.s)));

endmodule

// File: rtl/lcd_sync_gen.sv
`timescale 1ns/1ps
module lcd_sync_gen
    import lcd_sync_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              pclk_falling,
    output logic [15:0]       pix_x,
    output logic [15:0]       pix_y,
    output logic              line_start,
    output logic              frame_start
);

    tset_t shadow, active;
    logic  cmd_run, cmd_stop, running;
    pos_t  hcnt, vcnt, xcnt;

    lcd_sync_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .shadow   (shadow),
        .cmd_run  (cmd_run),
        .cmd_stop (cmd_stop)
    );

    lcd_sync_timing u_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .shadow   (shadow),
        .cmd_run  (cmd_run),
        .cmd_stop (cmd_stop),
        .running  (running),
        .hcnt     (hcnt),
        .vcnt     (vcnt),
        .xcnt     (xcnt),
        .active   (active)
    );

    lcd_sync_out u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .running      (running),
        .hcnt         (hcnt),
        .vcnt         (vcnt),
        .xcnt         (xcnt),
        .active       (active),
        .hsync        (hsync),
        .vsync        (vsync),
        .de           (de),
        .pclk_falling (pclk_falling),
        .pix_x        (pix_x),
        .pix_y        (pix_y),
        .line_start   (line_start),
        .frame_start  (frame_start)
    );

endmodule

// File: tb/tb_lcd_sync_gen.sv
`timescale 1ns/1ps
module tb_lcd_sync_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync, vsync, de, pclk_falling, line_start, frame_start;
    logic [15:0] pix_x, pix_y;

    int errs = 0;
    int checks = 0;
    string tag = "R10";

    // model: pending (shadow) and active settings
    logic [31:0] p_cfg = '0, p_hs = '0, p_vs = '0, p_tot = '0, p_hw = '0, p_vw = '0;
    logic [31:0] a_cfg = '0, a_hs = '0, a_vs = '0, a_tot = '0, a_hw = '0, a_vw = '0;
    int  mh = 0, mv = 0;
    bit  mrun = 0, mstop = 0;

    always #10 clk = ~clk;

    lcd_sync_gen dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .hsync        (hsync),
        .vsync        (vsync),
        .de           (de),
        .pclk_falling (pclk_falling),
        .pix_x        (pix_x),
        .pix_y        (pix_y),
        .line_start   (line_start),
        .frame_start  (frame_start)
    );

    task automatic chk(input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errs++;
            $display("FAIL %s %s: got %0d expected %0d (h=%0d v=%0d)", tag, what, got, exp, mh, mv);
        end
    endtask

    function automatic int hi(input logic [31:0] r); return int'(r[31:16]); endfunction
    function automatic int lo(input logic [31:0] r); return int'(r[15:0]); endfunction

    task automatic tick(input bit we, input int addr, input logic [31:0] data);
        int  hws, hwe, ht, vt, w;
        bit  ser, hsa, vsa, dea, wrap_f;
        ser = (a_cfg[3:0] == 4'hC);
        hws = hi(a_hw); hwe = lo(a_hw); ht = hi(a_tot); vt = lo(a_tot);
        w = hwe - hws;
        if (ser) begin hwe = hwe + 2*w; ht = ht + 2*w; end
        hsa = mrun && mh >= hi(a_hs) && mh < lo(a_hs);
        vsa = mrun && mv >= hi(a_vs) && mv < lo(a_vs);
        dea = mrun && mh >= hws && mh < hwe && mv >= hi(a_vw) && mv < lo(a_vw);
        chk("hsync", int'(hsync), int'(hsa ^ a_cfg[11]));
        chk("vsync", int'(vsync), int'(vsa ^ a_cfg[8]));
        chk("de", int'(de), int'(dea ^ a_cfg[9]));
        chk("pclk_falling", int'(pclk_falling), int'(a_cfg[10]));
        chk("pix_x", int'(pix_x), dea ? (ser ? (mh - hws) / 3 : mh - hws) : 0);
        chk("pix_y", int'(pix_y), dea ? mv - hi(a_vw) : 0);
        chk("line_start", int'(line_start), int'(mrun && mh == 0));
        chk("frame_start", int'(frame_start), int'(mrun && mh == 0 && mv == 0));

        wr_en   = we;
        wr_addr = we ? 3'(addr) : 3'd0;
        wr_data = we ? data : 32'd0;

        if (!mrun) begin
            if (we && addr == 6 && data[3] && !data[4]) begin
                mrun = 1; mstop = 0; mh = 0; mv = 0;
                a_cfg = p_cfg; a_hs = p_hs; a_vs = p_vs; a_tot = p_tot; a_hw = p_hw; a_vw = p_vw;
            end
        end else begin
            wrap_f = (mh + 1 >= ht) && (mv + 1 >= vt);
            if (wrap_f) begin
                mh = 0; mv = 0;
                if (mstop) begin
                    mrun = 0; mstop = 0;
                end else begin
                    a_cfg = p_cfg; a_hs = p_hs; a_vs = p_vs; a_tot = p_tot; a_hw = p_hw; a_vw = p_vw;
                end
            end else if (mh + 1 >= ht) begin
                mh = 0; mv = mv + 1;
            end else begin
                mh = mh + 1;
            end
            if (we && addr == 6) begin
                if (data[4]) mstop = 1;
                else if (data[3]) mstop = 0;
            end
        end
        if (we) begin
            case (addr)
                0: p_cfg = {20'd0, data[11:8], 4'd0, data[3:0]};
                1: p_hs = data;
                2: p_vs = data;
                3: p_tot = data;
                4: p_hw = data;
                5: p_vw = data;
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic idle_run(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        tag = "R10";
        idle_run(3);

        // writes while idle must not reach the outputs
        tag = "R9 R8 R1";
        tick(1, 0, 32'h0000_0B00);
        tick(1, 1, 32'h0000_0002);
        tick(1, 2, 32'h0000_0001);
        tick(1, 3, 32'h000B_0007);
        tick(1, 4, 32'h0005_0009);
        tick(1, 5, 32'h0003_0006);
        idle_run(3);
        tick(1, 0, 32'h0000_0000);

        // generic sweep, two full frames and more
        tag = "R1 R2 R3 R4 R7";
        tick(1, 6, 32'h0000_0008);
        idle_run(174);

        // polarity change mid-frame reaches the outputs at the next frame
        tag = "R5 R9";
        tick(1, 0, 32'h0000_0F00);
        idle_run(100);

        // stop request mid-frame; idle then rests at the inverted levels
        tag = "R7 R8";
        tick(1, 6, 32'h0000_0010);
        idle_run(80);

        // serial mode: three clocks per pixel
        tag = "R6";
        tick(1, 0, 32'h0000_000C);
        tick(1, 6, 32'h0000_0008);
        idle_run(266);

        // both control bits: stop wins
        tag = "R7 R8";
        tick(1, 6, 32'h0000_0018);
        idle_run(140);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        errs++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule